// File: doc/BRIEF.md
# Private Peripheral Region Address Decoder

This block sits at the entry to a 1 MB private peripheral window (offsets 0x00000 to 0xFFFFF, placed at base 0xE0000000). For each request it works out, without a clock, which responder owns the address. The candidates are the system-register block, the tick-timer block, the non-secure aliases of both, a small reliability (RAS) register block, and a default responder that owns every address no one else claims. The system-register and tick-timer blocks live outside this module. The decoder raises their select lines and passes them a block-relative offset. It then takes their read data and error flag back in the same cycle.

The RAS block and the default responder are built in. The response to every request is registered, so it appears one cycle after the request. Two parameters choose the build: one includes the non-secure aliases and one includes the RAS block. When an option is absent, its window falls to the default responder.

Top module: `ppb_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_valid`, `rsp_err` and `rsp_rdata` are all zero.
- R2: A request with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle without a request produces `rsp_valid`, `rsp_err` and `rsp_rdata` all zero on the next cycle.
- R3: Offsets 0xE000 to 0xEFFF that the timer does not claim go to the system-register block. `tgt_sys_sel` is 1, `tgt_ns` is 0 and `tgt_ofs` equals address bits [11:0]. The next response carries `sys_rdata` and `sys_err`.
- R4: Offsets 0xE010 to 0xE0EF go to the timer, which wins over the system registers there. `tgt_tmr_sel` is 1, `tgt_sys_sel` is 0 and `tgt_ofs` is address bits [11:0] minus 0x010. The next response carries `tmr_rdata` and `tmr_err`. At most one select is high in any cycle.
- R5: With `HAS_SEC`=1, offsets 0x2E000 to 0x2EFFF decode the same way as R3 and R4 (timer at 0x2E010 to 0x2E0EF), with `tgt_ns`=1.
- R6: An unclaimed address accessed privileged (`req_priv`=1) with a size of 1 to 8 bytes (`req_size` holds the byte count) responds OK with data zero. No select rises, so a write has no effect.
- R7: An unprivileged access (`req_priv`=0) to an unclaimed address responds with `rsp_err`=1 and data zero.
- R8: An access to an unclaimed address with `req_size` of 0 or above 8 responds with `rsp_err`=1, even when privileged.
- R9: With `HAS_RAS`=1, offsets 0x5000 to 0x5FFF form the RAS block. A privileged read there returns 0x43B at block offset 0xE10 and zero at offset 0xFC8 (no error records) and at every other offset, all with `rsp_err`=0.
- R10: Any unprivileged access to the RAS block responds with `rsp_err`=1. A privileged write there responds OK and changes nothing.
- R11: Every write response carries `rsp_rdata` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 20 | Offset within the peripheral window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | SZ_W (4) | Access size in bytes |
| req_priv | input | 1 | 1 = privileged access |
| tgt_sys_sel | output | 1 | Select for the system-register block |
| tgt_tmr_sel | output | 1 | Select for the tick-timer block |
| tgt_ns | output | 1 | Selected target is reached through the non-secure alias |
| tgt_ofs | output | 12 | Offset inside the selected target |
| sys_rdata | input | 64 | Read data from the system-register block |
| sys_err | input | 1 | Error flag from the system-register block |
| tmr_rdata | input | 64 | Read data from the tick-timer block |
| tmr_err | input | 1 | Error flag from the tick-timer block |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Response read data |
| rsp_err | output | 1 | Response error flag |

## Verification
Two functions share each cycle. The combinational decode of a new request raises its target select in the same cycle that the registered response of the previous request is shown. The bench issues requests back to back, so a privileged timer read follows an unprivileged default access or a RAS identity read. In every cycle it checks the select lines and offset of the new request against a bench address model. After the next edge it checks the previous request's data and error flag against the values the bench drove or predicted. A corrupted select or a response that leaks from one request into the next is therefore caught at once.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int ADDR_W = 20;
    localparam int OFS_W  = 12;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int DATA_W = 64;

    localparam logic [PAGE_W-1:0] SYS_PAGE    = 8'h0E;
    localparam logic [PAGE_W-1:0] SYS_NS_PAGE = 8'h2E;
    localparam logic [PAGE_W-1:0] RAS_PAGE    = 8'h05;

    localparam logic [OFS_W-1:0] TMR_LO   = 12'h010;
    localparam logic [OFS_W-1:0] TMR_SPAN = 12'h0E0;

    localparam logic [OFS_W-1:0]  RAS_ID_OFS  = 12'hE10;
    localparam logic [OFS_W-1:0]  RAS_DEV_OFS = 12'hFC8;
    localparam logic [DATA_W-1:0] RAS_ID_VAL  = 64'h43B;
    localparam logic [DATA_W-1:0] RAS_DEV_VAL = 64'h0;

    typedef enum logic [2:0] {
        RGN_DEFAULT,
        RGN_SYS,
        RGN_TMR,
        RGN_SYS_NS,
        RGN_TMR_NS,
        RGN_RAS
    } rgn_e;

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    function automatic logic in_tmr_window(input logic [OFS_W-1:0] ofs);
        return (ofs >= TMR_LO) && (ofs < TMR_LO + TMR_SPAN);
    endfunction

    function automatic logic is_sys_rgn(input rgn_e r);
        return (r == RGN_SYS) || (r == RGN_SYS_NS);
    endfunction

    function automatic logic is_tmr_rgn(input rgn_e r);
        return (r == RGN_TMR) || (r == RGN_TMR_NS);
    endfunction

endpackage

// File: rtl/ppb_addr_map.sv
module ppb_addr_map
    import ppb_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1,
    parameter bit HAS_RAS = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn
);

    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic              tmr_win;
    logic              hit_sys;
    logic              hit_ns;
    logic              hit_ras;

    assign page    = addr[ADDR_W-1:OFS_W];
    assign ofs     = addr[OFS_W-1:0];
    assign tmr_win = in_tmr_window(ofs);
    assign hit_sys = (page == SYS_PAGE);

    generate
        if (HAS_SEC) begin : g_ns_alias
            assign hit_ns = (page == SYS_NS_PAGE);
        end else begin : g_no_ns_alias
            assign hit_ns = 1'b0;
        end
        if (HAS_RAS) begin : g_ras
            assign hit_ras = (page == RAS_PAGE);
        end else begin : g_no_ras
            assign hit_ras = 1'b0;
        end
    endgenerate

    // Higher-priority timer window overrides the enclosing system page.
    always_comb begin
        rgn = RGN_DEFAULT;
        if (hit_sys) begin
            rgn = tmr_win ? RGN_TMR : RGN_SYS;
        end else if (hit_ns) begin
            rgn = tmr_win ? RGN_TMR_NS : RGN_SYS_NS;
        end else if (hit_ras) begin
            rgn = RGN_RAS;
        end
    end

endmodule

// File: rtl/ppb_local_resp.sv
module ppb_local_resp
    import ppb_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int SZ_W      = $clog2(MAX_BYTES + 1)
) (
    input  rgn_e             rgn,
    input  logic             write,
    input  logic             priv,
    input  logic [SZ_W-1:0]  size,
    input  logic [OFS_W-1:0] ofs,
    output rsp_t             rsp
);

    logic size_ok;

    assign size_ok = (size != '0) && (int'(size) <= MAX_BYTES);

    always_comb begin
        rsp = '0;
        if (rgn == RGN_RAS) begin
            rsp.err = !priv;
            if (priv && !write) begin
                unique case (ofs)
                    RAS_ID_OFS:  rsp.data = RAS_ID_VAL;
                    RAS_DEV_OFS: rsp.data = RAS_DEV_VAL;
                    default:     rsp.data = '0;
                endcase
            end
        end else begin
            rsp.err = !priv || !size_ok;
        end
    end

endmodule

// File: rtl/ppb_decoder.sv
module ppb_decoder
    import ppb_pkg::*;
#(
    parameter bit HAS_SEC   = 1'b1,
    parameter bit HAS_RAS   = 1'b1,
    parameter int MAX_BYTES = 8,
    parameter int SZ_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_priv,
    output logic              tgt_sys_sel,
    output logic              tgt_tmr_sel,
    output logic              tgt_ns,
    output logic [OFS_W-1:0]  tgt_ofs,
    input  logic [DATA_W-1:0] sys_rdata,
    input  logic              sys_err,
    input  logic [DATA_W-1:0] tmr_rdata,
    input  logic              tmr_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    rgn_e             rgn;
    rsp_t             local_rsp;
    rsp_t             rsp_next;
    rsp_t             rsp_q;
    logic             sys_hit;
    logic             tmr_hit;
    logic [OFS_W-1:0] raw_ofs;

    assign raw_ofs = req_addr[OFS_W-1:0];

    ppb_addr_map #(
        .HAS_SEC(HAS_SEC),
        .HAS_RAS(HAS_RAS)
    ) u_map (
        .addr(req_addr),
        .rgn (rgn)
    );

    ppb_local_resp #(
        .MAX_BYTES(MAX_BYTES),
        .SZ_W     (SZ_W)
    ) u_local (
        .rgn  (rgn),
        .write(req_write),
        .priv (req_priv),
        .size (req_size),
        .ofs  (raw_ofs),
        .rsp  (local_rsp)
    );

    assign sys_hit     = is_sys_rgn(rgn);
    assign tmr_hit     = is_tmr_rgn(rgn);
    assign tgt_sys_sel = req_valid && sys_hit;
    assign tgt_tmr_sel = req_valid && tmr_hit;
    assign tgt_ns      = req_valid && ((rgn == RGN_SYS_NS) || (rgn == RGN_TMR_NS));
    assign tgt_ofs     = tmr_hit ? (raw_ofs - TMR_LO) : raw_ofs;

    always_comb begin
        if (sys_hit) begin
            rsp_next = '{err: sys_err, data: sys_rdata};
        end else if (tmr_hit) begin
            rsp_next = '{err: tmr_err, data: tmr_rdata};
        end else begin
            rsp_next = local_rsp;
        end
        if (req_write) begin
            rsp_next.data = '0;
        end
        if (!req_valid) begin
            rsp_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_q     <= rsp_next;
        end
    end

    assign rsp_rdata = rsp_q.data;
    assign rsp_err   = rsp_q.err;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tgt_sys_sel, tgt_tmr_sel}));

    // R7
    unpriv_default_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && rgn == RGN_DEFAULT) |=> rsp_err);

    // R10
    unpriv_ras_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && rgn == RGN_RAS) |=> rsp_err);

    // R11
    write_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    // R9
    ras_id_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv && !req_write && rgn == RGN_RAS && raw_ofs == RAS_ID_OFS)
        |=> (rsp_rdata == RAS_ID_VAL && !rsp_err));

endmodule

// File: tb/tb_ppb_decoder.sv
`timescale 1ns/1ps
module tb_ppb_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_write;
    logic [3:0]  req_size;
    logic        req_priv;
    logic        tgt_sys_sel, tgt_tmr_sel, tgt_ns;
    logic [11:0] tgt_ofs;
    logic [63:0] sys_rdata, tmr_rdata;
    logic        sys_err, tmr_err;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ppb_decoder dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
        .tgt_sys_sel(tgt_sys_sel), .tgt_tmr_sel(tgt_tmr_sel), .tgt_ns(tgt_ns),
        .tgt_ofs(tgt_ofs), .sys_rdata(sys_rdata), .sys_err(sys_err),
        .tmr_rdata(tmr_rdata), .tmr_err(tmr_err), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 default, 1 sys, 2 timer, 3 sys alias, 4 timer alias, 5 RAS
    function automatic int model_rgn(input logic [19:0] a);
        int o = int'(a[11:0]);
        bit t = (o >= 16) && (o < 16 + 224);
        if (a[19:12] == 8'h0E) return t ? 2 : 1;
        if (a[19:12] == 8'h2E) return t ? 4 : 3;
        if (a[19:12] == 8'h05) return 5;
        return 0;
    endfunction

    task automatic do_req(input logic [19:0] a, input bit w, input logic [3:0] sz, input bit pr);
        int r = model_rgn(a);
        string tag;
        logic [63:0] exp_d;
        bit exp_e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz; req_priv = pr;
        sys_rdata = {$urandom, $urandom}; sys_err = 1'($urandom);
        tmr_rdata = {$urandom, $urandom}; tmr_err = 1'($urandom);
        case (r)
            1: tag = "R3";
            2: tag = "R4";
            3, 4: tag = "R5";
            5: tag = pr ? "R9" : "R10";
            default: tag = !pr ? "R7" : ((sz == 0 || sz > 8) ? "R8" : "R6");
        endcase
        #1;
        chk({tag, " sys_sel"}, 64'(tgt_sys_sel), 64'(r == 1 || r == 3));
        chk({tag, " tmr_sel"}, 64'(tgt_tmr_sel), 64'(r == 2 || r == 4));
        chk({tag, " ns"}, 64'(tgt_ns), 64'(r == 3 || r == 4));
        if (r >= 1 && r <= 4)
            chk({tag, " ofs"}, 64'(tgt_ofs), (r == 2 || r == 4) ? 64'(a[11:0] - 12'h10) : 64'(a[11:0]));
        case (r)
            1, 3: begin exp_e = sys_err; exp_d = sys_rdata; end
            2, 4: begin exp_e = tmr_err; exp_d = tmr_rdata; end
            5: begin
                exp_e = !pr;
                exp_d = (!pr || w) ? 64'h0 : ((a[11:0] == 12'hE10) ? 64'h43B : 64'h0);
            end
            default: begin exp_e = !pr || sz == 0 || sz > 8; exp_d = 64'h0; end
        endcase
        if (w) exp_d = 64'h0;
        @(posedge clk);
        #1;
        chk("R2 rsp_valid", 64'(rsp_valid), 64'h1);
        chk({tag, " rsp_err"}, 64'(rsp_err), 64'(exp_e));
        chk({tag, w ? " R11 rsp_rdata" : " rsp_rdata"}, rsp_rdata, exp_d);
    endtask

    task automatic do_idle();
        @(negedge clk);
        req_valid = 1'b0; req_addr = 20'(20'h0E000 + ($urandom % 256));
        #1;
        chk("R2 idle sels", 64'({tgt_sys_sel, tgt_tmr_sel}), 64'h0);
        @(posedge clk);
        #1;
        chk("R2 idle rsp", {rsp_valid, rsp_err, rsp_rdata[61:0]}, 64'h0);
    endtask

    function automatic logic [19:0] pick_addr();
        case ($urandom % 7)
            0: return {8'h0E, 12'($urandom)};
            1: return {8'h0E, 12'(12'h000 + ($urandom % 260))};
            2: return {8'h2E, 12'($urandom)};
            3: return {8'h2E, 12'(12'h000 + ($urandom % 260))};
            4: return {8'h05, 12'($urandom)};
            5: return {8'h05, (($urandom % 2) != 0) ? 12'hE10 : 12'hFC8};
            default: return 20'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20251));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_size = 4'd4; req_priv = 1'b1;
        sys_rdata = '0; sys_err = 1'b0; tmr_rdata = '0; tmr_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
        chk("R1 reset rsp", {rsp_err, rsp_rdata[62:0]}, 64'h0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 first cycle rsp_valid", 64'(rsp_valid), 64'h0);

        // Directed corners
        do_req(20'h0E000, 0, 4, 1);      // R3 base
        do_req(20'h0EFFF, 0, 1, 1);      // R3 top
        do_req(20'h0E00F, 0, 4, 1);      // R3 just below timer
        do_req(20'h0E010, 0, 4, 1);      // R4 timer base
        do_req(20'h0E0EF, 0, 4, 1);      // R4 timer top
        do_req(20'h0E0F0, 0, 4, 1);      // R3 just past timer
        do_req(20'h2E000, 0, 4, 1);      // R5 alias sys
        do_req(20'h2E010, 0, 4, 0);      // R5 alias timer
        do_req(20'h00000, 0, 4, 1);      // R6
        do_req(20'hFFFFF, 1, 8, 1);      // R6 write, R11
        do_req(20'h0DFFF, 0, 1, 0);      // R7
        do_req(20'h10000, 0, 0, 1);      // R8 size 0
        do_req(20'h10000, 0, 9, 1);      // R8 size 9
        do_req(20'h05E10, 0, 4, 1);      // R9 identity
        do_req(20'h05FC8, 0, 4, 1);      // R9 device id
        do_req(20'h05004, 0, 4, 1);      // R9 other
        do_req(20'h05E10, 0, 4, 0);      // R10 unprivileged
        do_req(20'h05E10, 1, 4, 1);      // R10 write ignored
        do_req(20'h05E10, 0, 4, 1);      // R10 value unchanged after write
        do_req(20'h0E004, 1, 4, 1);      // R11 write to sys
        do_idle();                       // R2
        // Back-to-back mixes
        do_req(20'h30000, 0, 4, 0);
        do_req(20'h0E020, 0, 4, 1);
        do_req(20'h05E10, 0, 4, 1);
        do_req(20'h2E0E0, 0, 2, 1);

        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 10) == 0) do_idle();
            else do_req(pick_addr(), 1'($urandom), 4'($urandom % 11), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule